// File: doc/BRIEF.md
# Dual-Output Waveform Timer Channel

This block is a single timer channel that produces two pulse-width modulated outputs from one shared up-counter. A clock selector turns the system clock into counting ticks, either by dividing it by 2, 8, 32 or 128, or by taking a slow-tick strobe of about 32 kHz that comes from outside the block. The counter counts up from zero. When it reaches the period value, it returns to zero on the next tick. Each output has a compare register of its own. Each output also has three action fields: one for its own compare event, one for the period event and one for the software trigger. Each action field can leave the output alone, set it or clear it.

Software programs the channel through a plain write port with valid, address and data signals. The writable words are the mode word, the two compare values, the period value and a control word. The control word can start the clock, stop the clock and issue a software trigger. The software trigger puts the counter and the prescaler back to zero and applies each output's trigger action in the same cycle. This gives a clean restart after a new configuration has been loaded. A duty of 0% or 100% is produced by programming only the trigger action, so that the output holds the level the trigger gave it.

Top module: `wtc_channel`

## Requirements
- R1: After reset, out_a and out_b are low, count is zero, and the counter stays at zero until a control write sets the start bit.
- R2: Mode bits [2:0] select the tick source. Values 0, 1, 2 and 3 divide the clock by 2, 8, 32 and 128. Values 4 to 7 count one tick for each clock cycle in which slow_tick is high. No ticks are produced while the clock is stopped.
- R3: On each tick the counter goes up by one. If the counter already equals the period value, it goes to zero instead. One full period therefore lasts period+1 ticks.
- R4: Each action field is 2 bits wide: 0 = no action, 1 = set, 2 = clear, 3 = no action. Output A's group sits at mode bits [8:3] and output B's group at mode bits [14:9]. Inside a group, bits [1:0] are the compare action, [3:2] the period action and [5:4] the trigger action. An output changes only on a tick or on a software trigger.
- R5: An output with compare=clear, period=set and trigger=set is high for (C+1) ticks of every period. An output with compare=set, period=clear and trigger=clear is high for (P-C) ticks. Here C is the output's compare value and P the period value, with C < P.
- R6: A control write with bit 2 set clears the counter and the prescaler at that clock edge. At the same edge it applies each output's trigger action.
- R7: Control bit 0 starts the clock and control bit 1 stops it. If both are written, stop wins. Stop written together with a trigger forces the outputs, leaves the counter at zero and keeps it there.
- R8: An output whose compare and period actions are both "no action" holds its trigger level for the whole period (0% or 100% duty).
- R9: When events coincide in one cycle, the software trigger wins over the period event, and the period event wins over the compare event.
- R10: Write addresses: 0 = mode, 1 = compare A, 2 = compare B, 3 = period, 4 = control. Compare and period writes take effect immediately, without shadowing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | Slow-clock strobe, used when the selector is 4 to 7 |
| wr_valid | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | CW | Write data |
| out_a | output | 1 | Waveform output A |
| out_b | output | 1 | Waveform output B |
| count | output | CW | Current counter value |

## Verification
The main waveform function is tried with a table of configurations. The table covers every divider setting and pairs normal polarity on one output with inverted polarity on the other. It includes a compare value of zero, a compare value equal to the period (which makes the period/compare priority decide the level), and trigger-only settings that hold 0% and 100%. Counting high cycles over two full periods tells apart errors in the divider, in the wrap point and in the action encoding. Directed cases then check the slow-tick path, a trigger that coincides with a period event, and stop written together with a trigger.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  localparam int NUM_OUT   = 2;
  localparam int SEL_W     = 3;
  localparam int GRP_W     = 6;
  localparam int MODE_W    = SEL_W + NUM_OUT * GRP_W;
  localparam int DIV_STEPS = 4;
  localparam int PRESC_W   = 2 * DIV_STEPS - 1;
  localparam int ADDR_W    = 3;

  localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMPA = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMPB = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_PER  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd4;

  localparam int CTL_START = 0;
  localparam int CTL_STOP  = 1;
  localparam int CTL_TRIG  = 2;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_RSV  = 2'd3
  } act_e;

  typedef struct packed {
    act_e on_trig;
    act_e on_per;
    act_e on_cmp;
  } out_act_t;
endpackage

// File: rtl/wtc_regs.sv
module wtc_regs
  import wtc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_valid,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [CW-1:0]                  wr_data,
  output logic [MODE_W-1:0]              mode_q,
  output logic [NUM_OUT-1:0][CW-1:0]     cmp_q,
  output logic [CW-1:0]                  per_q,
  output logic                           clk_on_q,
  output logic                           trig_hit
);
  logic [MODE_W-1:0]          mode_d;
  logic [NUM_OUT-1:0][CW-1:0] cmp_d;
  logic [CW-1:0]              per_d;
  logic                       clk_on_d;

  assign trig_hit = wr_valid && (wr_addr == ADDR_CTRL) && wr_data[CTL_TRIG];

  always_comb begin
    mode_d   = mode_q;
    cmp_d    = cmp_q;
    per_d    = per_q;
    clk_on_d = clk_on_q;
    if (wr_valid) begin
      case (wr_addr)
        ADDR_MODE: mode_d   = wr_data[MODE_W-1:0];
        ADDR_CMPA: cmp_d[0] = wr_data;
        ADDR_CMPB: cmp_d[1] = wr_data;
        ADDR_PER:  per_d    = wr_data;
        ADDR_CTRL: begin
          if (wr_data[CTL_STOP])       clk_on_d = 1'b0;
          else if (wr_data[CTL_START]) clk_on_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      cmp_q    <= '0;
      per_q    <= '0;
      clk_on_q <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      cmp_q    <= cmp_d;
      per_q    <= per_d;
      clk_on_q <= clk_on_d;
    end
  end
endmodule

// File: rtl/wtc_prescaler.sv
module wtc_prescaler
  import wtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [SEL_W-1:0] sel,
  input  logic             slow_tick,
  output logic             tick
);
  logic [PRESC_W-1:0] presc_q, presc_d;
  logic [PRESC_W:0]   span;
  logic [PRESC_W-1:0] mask;

  always_comb begin
    span = (PRESC_W+1)'(1) << {sel[1:0], 1'b1};
    mask = span[PRESC_W-1:0] - PRESC_W'(1);
    if (sel[2]) tick = run && slow_tick;
    else        tick = run && ((presc_q & mask) == mask);
  end

  always_comb begin
    presc_d = presc_q;
    if (clear)    presc_d = '0;
    else if (run) presc_d = presc_q + PRESC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) presc_q <= '0;
    else        presc_q <= presc_d;
  end
endmodule

// File: rtl/wtc_counter.sv
module wtc_counter
  import wtc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       clear,
  input  logic [CW-1:0]              per,
  input  logic [NUM_OUT-1:0][CW-1:0] cmp,
  output logic [CW-1:0]              cnt_q,
  output logic                       per_ev,
  output logic [NUM_OUT-1:0]         cmp_ev
);
  logic [CW-1:0] cnt_d;

  assign per_ev = tick && (cnt_q == per);

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_cmp
    assign cmp_ev[g] = tick && (cnt_q == cmp[g]);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (clear)       cnt_d = '0;
    else if (per_ev) cnt_d = '0;
    else if (tick)   cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wtc_output.sv
module wtc_output
  import wtc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  out_act_t act,
  input  logic     trig_ev,
  input  logic     per_ev,
  input  logic     cmp_ev,
  output logic     lvl_q
);
  logic lvl_d;

  function automatic logic resolve(input act_e a, input logic cur);
    case (a)
      ACT_SET: resolve = 1'b1;
      ACT_CLR: resolve = 1'b0;
      default: resolve = cur;
    endcase
  endfunction

  always_comb begin
    lvl_d = lvl_q;
    if (trig_ev)
      lvl_d = resolve(act.on_trig, lvl_q);
    else if (per_ev && (act.on_per == ACT_SET || act.on_per == ACT_CLR))
      lvl_d = resolve(act.on_per, lvl_q);
    else if (cmp_ev)
      lvl_d = resolve(act.on_cmp, lvl_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end
endmodule

// File: rtl/wtc_channel.sv
module wtc_channel
  import wtc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  output logic              out_a,
  output logic              out_b,
  output logic [CW-1:0]     count
);
  logic [MODE_W-1:0]          mode_q;
  logic [NUM_OUT-1:0][CW-1:0] cmp_q;
  logic [CW-1:0]              per_q;
  logic                       clk_on;
  logic                       trig_hit;
  logic                       tick;
  logic                       per_ev;
  logic [NUM_OUT-1:0]         cmp_ev;
  logic [NUM_OUT-1:0]         lvl;

  wtc_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .mode_q(mode_q), .cmp_q(cmp_q), .per_q(per_q),
    .clk_on_q(clk_on), .trig_hit(trig_hit)
  );

  wtc_prescaler u_presc (
    .clk(clk), .rst_n(rst_n), .run(clk_on), .clear(trig_hit),
    .sel(mode_q[SEL_W-1:0]), .slow_tick(slow_tick), .tick(tick)
  );

  wtc_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clear(trig_hit),
    .per(per_q), .cmp(cmp_q), .cnt_q(count), .per_ev(per_ev), .cmp_ev(cmp_ev)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    out_act_t act;
    assign act = out_act_t'(mode_q[SEL_W + g*GRP_W +: GRP_W]);
    wtc_output u_out (
      .clk(clk), .rst_n(rst_n), .act(act), .trig_ev(trig_hit),
      .per_ev(per_ev), .cmp_ev(cmp_ev[g]), .lvl_q(lvl[g])
    );
  end

  assign out_a = lvl[0];
  assign out_b = lvl[1];
endmodule

// File: rtl/wtc_channel_chk.sv
module wtc_channel_chk
  import wtc_pkg::*;
#(
  parameter int CW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [CW-1:0]     wr_data,
  input logic              clk_on,
  input logic              trig_hit,
  input logic              tick,
  input logic              out_a,
  input logic              out_b,
  input logic [CW-1:0]     count
);
  assert_trig_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |=> (count == '0));

  assert_stopped_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_on && !trig_hit) |=> $stable(count));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_hit |=> (count == '0 || count == $past(count) || count == $past(count) + CW'(1)));

  assert_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == ADDR_CTRL && wr_data[CTL_STOP]) |=> !clk_on);

  assert_out_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !trig_hit) |=> $stable({out_a, out_b}));

  assert_tick_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_on |-> !tick);
endmodule

bind wtc_channel wtc_channel_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .wr_data(wr_data), .clk_on(clk_on), .trig_hit(trig_hit), .tick(tick),
  .out_a(out_a), .out_b(out_b), .count(count)
);

// File: tb/tb_wtc_channel.sv
module tb_wtc_channel;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          slow_tick;
  logic          wr_valid;
  logic [2:0]    wr_addr;
  logic [CW-1:0] wr_data;
  logic          out_a, out_b;
  logic [CW-1:0] count;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  wtc_channel #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .out_a(out_a), .out_b(out_b),
    .count(count)
  );

  always #10 clk = ~clk;

  // columns: sel, period, cmpA, cmpB, styleA, styleB, highs A, highs B (two periods)
  // style: 0 normal, 1 inverted, 2 trigger-set only, 3 trigger-clear only
  localparam int NV = 5;
  localparam int TBL [NV][8] = '{
    '{0, 9, 3, 6, 0, 1,  16,  12},
    '{1, 4, 0, 4, 0, 0,  16,  80},
    '{2, 3, 2, 1, 1, 0,  64, 128},
    '{3, 1, 0, 0, 0, 1, 256, 256},
    '{0, 7, 2, 2, 2, 3,  32,   0}
  };

  function automatic int grp(input int style);
    case (style)
      0: grp = 2 | (1 << 2) | (1 << 4);
      1: grp = 1 | (2 << 2) | (2 << 4);
      2: grp = 1 << 4;
      default: grp = 2 << 4;
    endcase
  endfunction

  task automatic chk(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    wr_valid = 1'b1;
    wr_addr  = 3'(addr);
    wr_data  = CW'(data);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pulse_slow();
    slow_tick = 1'b1;
    @(negedge clk);
    slow_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog got=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; slow_tick = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 out_a in reset", out_a, 0);
    chk("R1 out_b in reset", out_b, 0);
    chk("R1 count in reset", count, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // configured but never started: counter must not move
    wr(3, 3);
    wr(0, 0 | (grp(0) << 3) | (grp(0) << 9));
    repeat (20) @(negedge clk);
    chk("R1 count idle before start", count, 0);
    chk("R1 out_a idle before start", out_a, 0);

    // table walk: R2 R3 R4 R5 R8 R9 R10
    for (int v = 0; v < NV; v++) begin
      int w;
      int ha;
      int hb;
      w  = 2 * (TBL[v][1] + 1) * (2 << (2 * TBL[v][0]));
      ha = 0;
      hb = 0;
      wr(0, TBL[v][0] | (grp(TBL[v][4]) << 3) | (grp(TBL[v][5]) << 9));
      wr(1, TBL[v][2]);
      wr(2, TBL[v][3]);
      wr(3, TBL[v][1]);
      wr(4, 5);
      for (int c = 0; c < w; c++) begin
        ha += int'(out_a);
        hb += int'(out_b);
        @(negedge clk);
      end
      chk($sformatf("R5 vector %0d out_a high cycles", v), ha, TBL[v][6]);
      chk($sformatf("R5 vector %0d out_b high cycles", v), hb, TBL[v][7]);
    end

    // R9: trigger (clear) coincides with period event (set) on slow tick, period 0
    wr(0, 4 | (((1 << 2) | (2 << 4)) << 3));
    wr(1, 5);
    wr(3, 0);
    wr(4, 1);
    wr_valid = 1'b1; wr_addr = 3'd4; wr_data = CW'(4); slow_tick = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; slow_tick = 1'b0;
    chk("R9 trigger beats period event", out_a, 0);
    chk("R6 count zero after trigger", count, 0);
    pulse_slow();
    chk("R9 period event sets alone", out_a, 1);

    // R2: slow tick source counts only strobes
    wr(3, 9);
    pulse_slow(); pulse_slow(); pulse_slow();
    chk("R2 three slow ticks", count, 3);
    repeat (20) @(negedge clk);
    chk("R2 no strobe no count", count, 3);

    // R7: stop together with trigger
    wr(4, 6);
    chk("R7 trigger forces out_a low", out_a, 0);
    chk("R7 count cleared", count, 0);
    pulse_slow();
    chk("R7 stopped ignores tick", count, 0);
    wr(4, 3);
    pulse_slow();
    chk("R7 stop wins over start", count, 0);
    wr(4, 1);
    pulse_slow();
    chk("R7 restart counts", count, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule